// File: doc/BRIEF.md
# T3/E3 C-bit Parity Performance Counters

This block keeps two saturating 16-bit event counters for a received T3 or E3 stream. An upstream framer hands it, once per M-frame, the three redundant CP bits together with the parity it computed locally over the information bits. In a separate once-per-M-frame strobe it receives the three far-end block error bits, or in E3 mode the remote alarm bit on the lowest of those three bit lines. The first counter records parity errors. A parity error is judged by taking the 2-of-3 majority of the CP bits and comparing it with the local parity. The second counter records far-end block errors in T3 C-bit parity mode and remote alarm indications in E3 mode.

Software-side logic pulses a latch strobe to take a snapshot. In that cycle each live count moves into a holding register and the live count restarts. The held values are read back through an address-selected port with one clock of latency. A control input decides whether events are still counted while the framer reports loss of frame.

Top module: `cbitPerfCounters`

## Requirements
- R1: A synchronous active-high `rst` clears both live counts and both held counts. `rdData` reads 0 in the cycle after reset.
- R2: In T3 C-bit parity mode (`modeE3`=0, `cbitMode`=1), a `cpStrobe` cycle increments the parity counter when the majority of `cpBits` (1 if at least two bits are 1) differs from `calcParity`.
- R3: In T3 C-bit parity mode, a `febeStrobe` cycle increments the block counter when `febeBits` is not 3'b111.
- R4: In E3 mode (`modeE3`=1), a `febeStrobe` cycle increments the block counter when `febeBits[0]` (the alarm bit) is 1. The parity counter does not change in E3 mode.
- R5: In T3 mode without C-bit parity (`modeE3`=0, `cbitMode`=0), neither counter changes.
- R6: While `lofActive`=1 and `countInLof`=0, neither counter changes. With `countInLof`=1, counting continues during loss of frame.
- R7: Each counter saturates at 16'hFFFF instead of wrapping.
- R8: On `latchStrobe`, each live count is copied to its holding register and the live count is cleared in the same cycle. An event in that same cycle makes the fresh count 1.
- R9: `rdData` returns the held parity count when `rdAddr`=0 and the held block count when `rdAddr`=1. The value appears one clock after the address is presented.
- R10: Bit values presented while their strobe is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeE3 | input | 1 | 1 selects E3, 0 selects T3 |
| cbitMode | input | 1 | 1 selects C-bit parity framing in T3 |
| lofActive | input | 1 | Loss of frame reported by the framer |
| countInLof | input | 1 | 1 keeps counting during loss of frame |
| cpStrobe | input | 1 | Once-per-M-frame qualifier for the CP bits |
| cpBits | input | 3 | The three received CP bits |
| calcParity | input | 1 | Locally computed parity over the information bits |
| febeStrobe | input | 1 | Once-per-M-frame qualifier for the block error bits |
| febeBits | input | 3 | Received block error bits; bit 0 carries the alarm bit in E3 |
| latchStrobe | input | 1 | Snapshot-and-clear request |
| rdAddr | input | 1 | Read select: 0 parity, 1 block |
| rdData | output | 16 | Registered read data |

## Verification
The latch strobe can land in the same cycle as a parity or block error event. Both the snapshot and the restarted count must then be right. The bench provokes this by holding error strobes active across a latch. It then takes a second latch with no event, so the restarted count of 1 can be read back through the port. Saturation and the latch also meet: after more than 65535 back-to-back events, the snapshot must hold 16'hFFFF. A behavioural model in the bench tracks every count and the expected read value, and the port is compared with it on every clock.

// File: rtl/cbitPerfPkg.sv
package cbitPerfPkg;

  localparam int NUM_CNT = 2;
  localparam int IDX_PARITY = 0;
  localparam int IDX_BLOCK = 1;

  typedef struct packed {
    logic incParity;
    logic incBlock;
    logic latch;
  } cntStrobes_t;

endpackage

// File: rtl/cbitSatCounter.sv
module cbitSatCounter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             latch,
  output logic [CNT_W-1:0] liveCnt,
  output logic [CNT_W-1:0] holdCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic atMax;
  assign atMax = (liveCnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      liveCnt <= '0;
      holdCnt <= '0;
    end else if (latch) begin
      holdCnt <= liveCnt;
      liveCnt <= inc ? CNT_ONE : '0;
    end else if (inc && !atMax) begin
      liveCnt <= liveCnt + CNT_ONE;
    end
  end

endmodule

// File: rtl/cbitCtrl.sv
module cbitCtrl
  import cbitPerfPkg::*;
#(
  parameter int CP_W = 3,
  parameter int FEBE_W = 3
) (
  input  logic              modeE3,
  input  logic              cbitMode,
  input  logic              lofActive,
  input  logic              countInLof,
  input  logic              cpStrobe,
  input  logic [CP_W-1:0]   cpBits,
  input  logic              calcParity,
  input  logic              febeStrobe,
  input  logic [FEBE_W-1:0] febeBits,
  input  logic              latchStrobe,
  output cntStrobes_t       strobes
);

  localparam int MAJ_THRESH = CP_W / 2 + 1;

  logic majVote;
  logic lofOk;
  logic parityOn;
  logic blockHit;
  int   onesCnt;

  always_comb begin
    onesCnt = 0;
    for (int i = 0; i < CP_W; i++) begin
      onesCnt = onesCnt + int'(cpBits[i]);
    end
    majVote = (onesCnt >= MAJ_THRESH);
  end

  assign lofOk    = !lofActive || countInLof;
  assign parityOn = !modeE3 && cbitMode;
  assign blockHit = modeE3 ? febeBits[0] : (cbitMode && !(&febeBits));

  always_comb begin
    strobes.incParity = cpStrobe && parityOn && (majVote != calcParity) && lofOk;
    strobes.incBlock  = febeStrobe && blockHit && lofOk;
    strobes.latch     = latchStrobe;
  end

endmodule

// File: rtl/cbitDatapath.sv
module cbitDatapath
  import cbitPerfPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  cntStrobes_t                    strobes,
  input  logic                           rdAddr,
  output logic [CNT_W-1:0]               rdData,
  output logic [NUM_CNT-1:0][CNT_W-1:0]  liveVec,
  output logic [NUM_CNT-1:0][CNT_W-1:0]  holdVec
);

  logic [NUM_CNT-1:0] incVec;

  always_comb begin
    incVec = '0;
    incVec[IDX_PARITY] = strobes.incParity;
    incVec[IDX_BLOCK]  = strobes.incBlock;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    cbitSatCounter #(.CNT_W(CNT_W)) i_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc    (incVec[g]),
      .latch  (strobes.latch),
      .liveCnt(liveVec[g]),
      .holdCnt(holdVec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else begin
      rdData <= holdVec[rdAddr];
    end
  end

endmodule

// File: rtl/cbitPerfCounters.sv
module cbitPerfCounters
  import cbitPerfPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeE3,
  input  logic             cbitMode,
  input  logic             lofActive,
  input  logic             countInLof,
  input  logic             cpStrobe,
  input  logic [2:0]       cpBits,
  input  logic             calcParity,
  input  logic             febeStrobe,
  input  logic [2:0]       febeBits,
  input  logic             latchStrobe,
  input  logic             rdAddr,
  output logic [CNT_W-1:0] rdData
);

  cntStrobes_t strobes;
  logic [NUM_CNT-1:0][CNT_W-1:0] liveVec;
  logic [NUM_CNT-1:0][CNT_W-1:0] holdVec;
  logic [CNT_W-1:0] liveParity;
  logic [CNT_W-1:0] liveBlock;
  logic [CNT_W-1:0] holdParity;
  logic [CNT_W-1:0] holdBlock;

  cbitCtrl #(.CP_W(3), .FEBE_W(3)) i_ctrl (
    .modeE3     (modeE3),
    .cbitMode   (cbitMode),
    .lofActive  (lofActive),
    .countInLof (countInLof),
    .cpStrobe   (cpStrobe),
    .cpBits     (cpBits),
    .calcParity (calcParity),
    .febeStrobe (febeStrobe),
    .febeBits   (febeBits),
    .latchStrobe(latchStrobe),
    .strobes    (strobes)
  );

  cbitDatapath #(.CNT_W(CNT_W)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .liveVec(liveVec),
    .holdVec(holdVec)
  );

  assign liveParity = liveVec[IDX_PARITY];
  assign liveBlock  = liveVec[IDX_BLOCK];
  assign holdParity = holdVec[IDX_PARITY];
  assign holdBlock  = holdVec[IDX_BLOCK];

endmodule

// File: rtl/cbitPerfCountersChk.sv
module cbitPerfCountersChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             modeE3,
  input logic             cbitMode,
  input logic             lofActive,
  input logic             countInLof,
  input logic             latchStrobe,
  input logic             rdAddr,
  input logic [CNT_W-1:0] rdData,
  input logic [CNT_W-1:0] liveParity,
  input logic [CNT_W-1:0] liveBlock,
  input logic [CNT_W-1:0] holdParity,
  input logic [CNT_W-1:0] holdBlock
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (rdData == '0 && liveParity == '0 && liveBlock == '0 && holdParity == '0 && holdBlock == '0)); // R1

  AST_E3_PARITY_FROZEN: assert property (@(posedge clk) disable iff (rst) (modeE3 && !latchStrobe) |=> $stable(liveParity)); // R4

  AST_PLAIN_T3_FROZEN: assert property (@(posedge clk) disable iff (rst) (!modeE3 && !cbitMode && !latchStrobe) |=> ($stable(liveParity) && $stable(liveBlock))); // R5

  AST_LOF_FROZEN: assert property (@(posedge clk) disable iff (rst) (lofActive && !countInLof && !latchStrobe) |=> ($stable(liveParity) && $stable(liveBlock))); // R6

  AST_NO_WRAP_PARITY: assert property (@(posedge clk) disable iff (rst) (liveParity == CNT_MAX && !latchStrobe) |=> liveParity == CNT_MAX); // R7

  AST_NO_WRAP_BLOCK: assert property (@(posedge clk) disable iff (rst) (liveBlock == CNT_MAX && !latchStrobe) |=> liveBlock == CNT_MAX); // R7

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst) latchStrobe |=> (holdParity == $past(liveParity) && holdBlock == $past(liveBlock))); // R8

  AST_LATCH_FRESH: assert property (@(posedge clk) disable iff (rst) latchStrobe |=> (liveParity <= CNT_ONE && liveBlock <= CNT_ONE)); // R8

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) !latchStrobe |=> rdData == ($past(rdAddr) ? $past(holdBlock) : $past(holdParity))); // R9

endmodule

bind cbitPerfCounters cbitPerfCountersChk #(.CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .modeE3     (modeE3),
  .cbitMode   (cbitMode),
  .lofActive  (lofActive),
  .countInLof (countInLof),
  .latchStrobe(latchStrobe),
  .rdAddr     (rdAddr),
  .rdData     (rdData),
  .liveParity (liveParity),
  .liveBlock  (liveBlock),
  .holdParity (holdParity),
  .holdBlock  (holdBlock)
);

// File: tb/test_cbitPerfCounters.sv
module test_cbitPerfCounters;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_MAXV = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeE3 = 1'b0;
  logic cbitMode = 1'b1;
  logic lofActive = 1'b0;
  logic countInLof = 1'b0;
  logic cpStrobe = 1'b0;
  logic [2:0] cpBits = 3'b000;
  logic calcParity = 1'b0;
  logic febeStrobe = 1'b0;
  logic [2:0] febeBits = 3'b111;
  logic latchStrobe = 1'b0;
  logic rdAddr = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  bit started = 1'b0;

  int mLive[2];
  int mHold[2];
  int expRd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbitPerfCounters i_cbitPerfCounters (
    .clk        (clk),
    .rst        (rst),
    .modeE3     (modeE3),
    .cbitMode   (cbitMode),
    .lofActive  (lofActive),
    .countInLof (countInLof),
    .cpStrobe   (cpStrobe),
    .cpBits     (cpBits),
    .calcParity (calcParity),
    .febeStrobe (febeStrobe),
    .febeBits   (febeBits),
    .latchStrobe(latchStrobe),
    .rdAddr     (rdAddr),
    .rdData     (rdData)
  );

  // Behavioural reference model, advanced on every rising edge.
  always @(posedge clk) begin
    bit lofOk;
    bit evP;
    bit evB;
    int ones;
    if (rst) begin
      mLive[0] = 0; mLive[1] = 0; mHold[0] = 0; mHold[1] = 0; expRd = 0;
    end else begin
      expRd = mHold[int'(rdAddr)];
      lofOk = !lofActive || countInLof;
      ones = int'(cpBits[0]) + int'(cpBits[1]) + int'(cpBits[2]);
      evP = cpStrobe && !modeE3 && cbitMode && ((ones >= 2) != calcParity) && lofOk;
      if (modeE3) evB = febeStrobe && febeBits[0] && lofOk;
      else evB = febeStrobe && cbitMode && (febeBits != 3'b111) && lofOk;
      if (latchStrobe) begin
        mHold[0] = mLive[0]; mHold[1] = mLive[1];
        mLive[0] = evP ? 1 : 0; mLive[1] = evB ? 1 : 0;
      end else begin
        if (evP && mLive[0] < CNT_MAXV) mLive[0]++;
        if (evB && mLive[1] < CNT_MAXV) mLive[1]++;
      end
    end
  end

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (int'(rdData) != expRd) begin
        fails++;
        $display("FAIL %s: rdData actual %0d expected %0d at %0t", curReq, rdData, expRd, $time);
      end
    end
  end

  task automatic checkVal(input string req, input int exp);
    checks++;
    if (int'(rdData) != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, rdData, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cpEvent(input logic [2:0] b, input logic p);
    cpStrobe = 1'b1; cpBits = b; calcParity = p;
    @(negedge clk);
    cpStrobe = 1'b0;
  endtask

  task automatic febeEvent(input logic [2:0] b);
    febeStrobe = 1'b1; febeBits = b;
    @(negedge clk);
    febeStrobe = 1'b0;
  endtask

  task automatic doLatch();
    latchStrobe = 1'b1;
    @(negedge clk);
    latchStrobe = 1'b0;
  endtask

  task automatic readHeld(input logic a, input string req, input int exp);
    rdAddr = a;
    @(negedge clk);
    checkVal(req, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1 - 1);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    started = 1'b1;
    @(negedge clk);
    curReq = "R1";
    readHeld(1'b0, "R1", 0);
    readHeld(1'b1, "R1", 0);

    // R2: every CP pattern against both parity values, 8 mismatches
    curReq = "R2";
    for (int b = 0; b < 8; b++) begin
      cpEvent(3'(b), 1'b0);
      cpEvent(3'(b), 1'b1);
    end
    doLatch();
    readHeld(1'b0, "R2", 8);

    // R3 and R10: all FEBE patterns, 7 not all-ones; unstrobed bits ignored
    curReq = "R3";
    for (int b = 0; b < 8; b++) febeEvent(3'(b));
    curReq = "R10";
    cpBits = 3'b111; calcParity = 1'b0; febeBits = 3'b000;
    idle(4);
    doLatch();
    readHeld(1'b1, "R3", 7);
    readHeld(1'b0, "R10", 0);

    // R4: E3 alarm counting, parity frozen
    curReq = "R4";
    modeE3 = 1'b1;
    for (int i = 0; i < 5; i++) febeEvent(3'b001);
    for (int i = 0; i < 3; i++) febeEvent(3'b110);
    for (int i = 0; i < 4; i++) cpEvent(3'b111, 1'b0);
    doLatch();
    readHeld(1'b1, "R4", 5);
    readHeld(1'b0, "R4", 0);

    // R5: plain T3, nothing counts
    curReq = "R5";
    modeE3 = 1'b0; cbitMode = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cpEvent(3'b000, 1'b1);
      febeEvent(3'b000);
    end
    doLatch();
    readHeld(1'b0, "R5", 0);
    readHeld(1'b1, "R5", 0);

    // R6: loss of frame gating
    curReq = "R6";
    cbitMode = 1'b1; lofActive = 1'b1; countInLof = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cpEvent(3'b011, 1'b0);
      febeEvent(3'b011);
    end
    countInLof = 1'b1;
    for (int i = 0; i < 2; i++) begin
      cpEvent(3'b011, 1'b0);
      febeEvent(3'b011);
    end
    lofActive = 1'b0; countInLof = 1'b0;
    doLatch();
    readHeld(1'b0, "R6", 2);
    readHeld(1'b1, "R6", 2);

    // R8: latch meets an event in the same cycle
    curReq = "R8";
    for (int i = 0; i < 3; i++) cpEvent(3'b110, 1'b0);
    cpStrobe = 1'b1; cpBits = 3'b110; calcParity = 1'b0;
    febeStrobe = 1'b1; febeBits = 3'b100;
    latchStrobe = 1'b1;
    @(negedge clk);
    cpStrobe = 1'b0; febeStrobe = 1'b0; latchStrobe = 1'b0;
    readHeld(1'b0, "R8", 3);
    readHeld(1'b1, "R8", 0);
    doLatch();
    readHeld(1'b0, "R8", 1);
    readHeld(1'b1, "R8", 1);

    // R9: address change takes one clock to appear
    curReq = "R9";
    readHeld(1'b0, "R9", 1);
    rdAddr = 1'b1;
    checkVal("R9", 1);
    doLatch();
    readHeld(1'b1, "R9", 0);

    // R7: saturation of both counters
    curReq = "R7";
    cpStrobe = 1'b1; cpBits = 3'b111; calcParity = 1'b0;
    febeStrobe = 1'b1; febeBits = 3'b010;
    idle(CNT_MAXV + 10);
    cpStrobe = 1'b0; febeStrobe = 1'b0;
    doLatch();
    readHeld(1'b0, "R7", CNT_MAXV);
    readHeld(1'b1, "R7", CNT_MAXV);

    // R1: reset mid-run clears held values
    curReq = "R1";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    readHeld(1'b0, "R1", 0);
    readHeld(1'b1, "R1", 0);

    started = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule